// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a single-port synchronous memory with a word made of byte lanes (four 8-bit lanes by default) and a depth set by parameter. Commands are taken on every enabled clock edge. Reads and writes can follow one another on consecutive cycles with no idle slot between them. Write data is taken, and read data is driven, two enabled edges after the command edge. Because both directions share that fixed latency, the data port never needs a turnaround cycle.

A command edge with the step strobe low loads a new address from the pins and starts a cycle. The same edge latches the direction and seeds a burst counter. While a burst is in progress, an edge with the step strobe high ignores the address pins and the direction pin. It moves to the next word of an aligned group of four, and the two low address bits wrap. Deselecting the chip ends the burst, and the output enable falls two edges later. A high level on the active-low clock enable removes that edge from the block entirely.

Top module: `nwt_sram`

## Requirements
- R1: On an enabled edge with `step`=0 and `sel_n`=0, a command starts at `addr`; `is_read`=0 makes it a write and `is_read`=1 makes it a read.
- R2: A read command drives `rdata_oe`=1 and `rdata` = stored word after the second enabled edge following its command edge.
- R3: A write command takes `wdata` and `lane_we_n` at the second enabled edge after its command edge; values on those pins at any other edge change no stored data.
- R4: On an enabled edge with `step`=1 during a burst, `addr` and `is_read` are ignored; the command has the direction latched at the burst's load.
- R5: Each burst step sets address bits [1:0] to the previous burst address bits [1:0] plus 1 modulo 4; the upper bits stay those of the loaded address.
- R6: An enabled edge with `step`=0 and `sel_n`=1 is a deselect: it ends any burst, and `rdata_oe` is 0 after the second enabled edge that follows it.
- R7: An enabled edge with `step`=1 and no burst in progress is a no-operation: no write, and `rdata_oe`=0 two enabled edges later.
- R8: An edge with `cke_n`=1 is ignored: stored words, the burst state, the command pipeline, `rdata` and `rdata_oe` keep their values, and the edge does not count toward any latency.
- R9: `lane_we_n[i]`=0 writes `wdata[8i+7:8i]`; lanes whose bit is 1 keep their old byte; any subset, including a single lane or all four, is allowed.
- R10: A read issued on the edge right after a write to the same address returns the merged word of that write, and reads and writes may alternate on every edge.
- R11: Synchronous reset (`rst`=1) clears `rdata_oe` to 0, empties the command pipeline to no-operations, and ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low; 1 ignores the edge |
| sel_n | input | 1 | Chip select, active low, looked at on load edges |
| step | input | 1 | 0 = load a new command, 1 = advance the burst |
| is_read | input | 1 | Direction on load edges: 1 read, 0 write |
| addr | input | $clog2(DEPTH) | Word address, used on load edges |
| lane_we_n | input | LANES | Per-lane write enables, active low, taken two edges after a write command |
| wdata | input | LANES*LANE_W | Write data, taken two edges after a write command |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | Output enable for `rdata`; 0 means the bus floats |

## Verification
The embedded assertions take it for granted that every control input holds a known 0 or 1 at each edge. They also assume reset is applied on the first edge, so that the burst and pipeline state are defined before any property is judged. The bench drives the controls only from tasks that assign explicit levels, starts with a reset, and makes every read target a word written earlier in the run. Payload pins are driven with random values on every cycle that is not a write-data slot. This shows that only the two-edge slot reaches the memory.

// File: rtl/nwt_sram_pkg.sv
package nwt_sram_pkg;

  // One command slot travelling down the pipeline
  typedef struct packed {
    logic live;  // slot carries a memory access
    logic wr;    // 1 = write, 0 = read
  } nwt_op_t;

endpackage

// File: rtl/nwt_sram_ctrl.sv
module nwt_sram_ctrl
  import nwt_sram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke_n,
  input  logic          sel_n,
  input  logic          step,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  output nwt_op_t       op_q,
  output logic [AW-1:0] addr_q
);

  logic          act_q;     // burst in progress
  logic          dir_wr_q;  // direction latched at load
  logic [AW-1:0] cnt_q;     // burst address
  logic [1:0]    nxt_lo;
  logic [AW-1:0] nxt_addr;

  assign nxt_lo   = cnt_q[1:0] + 2'd1;
  assign nxt_addr = {cnt_q[AW-1:2], nxt_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      dir_wr_q <= 1'b0;
      cnt_q    <= '0;
      op_q     <= '0;
      addr_q   <= '0;
    end else if (!cke_n) begin
      if (!step) begin
        if (!sel_n) begin
          act_q    <= 1'b1;
          dir_wr_q <= !is_read;
          cnt_q    <= addr;
          op_q     <= '{live: 1'b1, wr: !is_read};
          addr_q   <= addr;
        end else begin
          act_q <= 1'b0;
          op_q  <= '0;
        end
      end else if (act_q) begin
        cnt_q  <= nxt_addr;
        op_q   <= '{live: 1'b1, wr: dir_wr_q};
        addr_q <= nxt_addr;
      end else begin
        op_q <= '0;
      end
    end
  end

  AST_LOAD_TAKES_PINS: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !step && !sel_n) |=> (op_q.live && addr_q == $past(addr) && op_q.wr == !$past(is_read))); // R1

  AST_STEP_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && step && act_q) |=> (op_q.live && op_q.wr == $past(dir_wr_q))); // R4

  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && step && act_q) |=> (addr_q[1:0] == $past(cnt_q[1:0]) + 2'd1 && addr_q[AW-1:2] == $past(cnt_q[AW-1:2]))); // R5

  AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !step && sel_n) |=> (!op_q.live && !act_q)); // R6

  AST_IDLE_STEP_NOP: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && step && !act_q) |=> !op_q.live); // R7

  AST_CTRL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> ($stable(op_q) && $stable(addr_q) && $stable(act_q) && $stable(cnt_q))); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!op_q.live && !act_q)); // R11

endmodule

// File: rtl/nwt_sram_pipe.sv
module nwt_sram_pipe
  import nwt_sram_pkg::*;
#(
  parameter int AW     = 10,
  parameter int STAGES = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke_n,
  input  nwt_op_t       op_i,
  input  logic [AW-1:0] ad_i,
  output nwt_op_t       op_o,
  output logic [AW-1:0] ad_o
);

  nwt_op_t       op_r [STAGES];
  logic [AW-1:0] ad_r [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) begin
        op_r[k] <= '0;
        ad_r[k] <= '0;
      end
    end else if (!cke_n) begin
      op_r[0] <= op_i;
      ad_r[0] <= ad_i;
      for (int k = 1; k < STAGES; k++) begin
        op_r[k] <= op_r[k-1];
        ad_r[k] <= ad_r[k-1];
      end
    end
  end

  assign op_o = op_r[STAGES-1];
  assign ad_o = ad_r[STAGES-1];

  AST_PIPE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> ($stable(op_o) && $stable(ad_o))); // R8

  AST_PIPE_CLEARED: assert property (@(posedge clk)
    rst |=> !op_o.live); // R11

endmodule

// File: rtl/nwt_sram_array.sv
module nwt_sram_array
  import nwt_sram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke_n,
  input  nwt_op_t          op,
  input  logic [AW-1:0]    ad,
  input  logic [LANES-1:0] lane_we_n,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);

  logic [DW-1:0] mem [DEPTH];
  logic          do_wr;
  logic          do_rd;

  assign do_wr = !cke_n && op.live && op.wr;
  assign do_rd = !cke_n && op.live && !op.wr;

  // Byte-enabled write port
  always_ff @(posedge clk) begin
    if (do_wr) begin
      for (int l = 0; l < LANES; l++) begin
        if (!lane_we_n[l]) mem[ad][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  // Registered read port with enable
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else if (!cke_n) begin
      rdata_oe <= op.live && !op.wr;
      if (do_rd) rdata <= mem[ad];
    end
  end

  AST_OUT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> ($stable(rdata) && $stable(rdata_oe))); // R8

  AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (rst)
    do_wr |=> !rdata_oe); // R3

endmodule

// File: rtl/nwt_sram.sv
module nwt_sram
  import nwt_sram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cke_n,
  input  logic                        sel_n,
  input  logic                        step,
  input  logic                        is_read,
  input  logic [$clog2(DEPTH)-1:0]    addr,
  input  logic [LANES-1:0]            lane_we_n,
  input  logic [LANES*LANE_W-1:0]     wdata,
  output logic [LANES*LANE_W-1:0]     rdata,
  output logic                        rdata_oe
);

  localparam int AW = $clog2(DEPTH);

  nwt_op_t       s1_op, s2_op;
  logic [AW-1:0] s1_ad, s2_ad;

  nwt_sram_ctrl #(.AW(AW)) i_ctrl (
    .clk(clk), .rst(rst), .cke_n(cke_n), .sel_n(sel_n), .step(step),
    .is_read(is_read), .addr(addr), .op_q(s1_op), .addr_q(s1_ad)
  );

  nwt_sram_pipe #(.AW(AW), .STAGES(1)) i_pipe (
    .clk(clk), .rst(rst), .cke_n(cke_n),
    .op_i(s1_op), .ad_i(s1_ad), .op_o(s2_op), .ad_o(s2_ad)
  );

  nwt_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk(clk), .rst(rst), .cke_n(cke_n), .op(s2_op), .ad(s2_ad),
    .lane_we_n(lane_we_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && s2_op.live && !s2_op.wr) |=> rdata_oe); // R2

  AST_NOP_FLOATS: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !s2_op.live) |=> !rdata_oe); // R6

endmodule

// File: tb/test_nwt_sram.sv
`timescale 1ns/1ps
module test_nwt_sram;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst, cke_n, sel_n, step, is_read, rdata_oe;
  logic [AW-1:0] addr;
  logic [3:0]    lane_we_n;
  logic [31:0]   wdata, rdata;

  always #2.5 clk = ~clk;

  nwt_sram i_nwt_sram (
    .clk(clk), .rst(rst), .cke_n(cke_n), .sel_n(sel_n), .step(step),
    .is_read(is_read), .addr(addr), .lane_we_n(lane_we_n), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int checks = 0, errors = 0;
  string tag = "R11";
  bit done = 0;

  // Reference model state
  logic [31:0] mm [DEPTH];
  bit p1v, p1w, p2v, p2w;
  logic [AW-1:0] p1a, p2a, cnt;
  logic [3:0]  p1be, p2be;
  logic [31:0] p1d, p2d;
  bit act, dirw;
  bit exp_oe;
  logic [31:0] exp_rd;

  task automatic compare();
    checks++;
    if (rdata_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: rdata_oe=%0b expected %0b", tag, rdata_oe, exp_oe);
    end else if (exp_oe && rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", tag, rdata, exp_rd);
    end
  endtask

  // One clock: drive, model the edge, compare after it
  task automatic cyc(input bit r, input bit off, input bit sel, input bit stp,
                     input bit rd, input logic [AW-1:0] a,
                     input logic [3:0] pbe, input logic [31:0] pd);
    rst = r; cke_n = off; sel_n = sel; step = stp; is_read = rd; addr = a;
    if (!r && !off && p2v && p2w) begin
      wdata = p2d; lane_we_n = p2be;
    end else begin
      wdata = $urandom; lane_we_n = 4'($urandom);
    end
    @(posedge clk);
    if (r) begin
      p1v = 0; p2v = 0; act = 0; exp_oe = 0;
    end else if (!off) begin
      if (p2v && p2w) begin
        for (int l = 0; l < 4; l++)
          if (!p2be[l]) mm[p2a][l*8 +: 8] = p2d[l*8 +: 8];
      end
      exp_oe = p2v && !p2w;
      if (exp_oe) exp_rd = mm[p2a];
      p2v = p1v; p2w = p1w; p2a = p1a; p2be = p1be; p2d = p1d;
      if (!stp) begin
        if (!sel) begin
          act = 1; dirw = !rd; cnt = a;
          p1v = 1; p1w = !rd; p1a = a;
        end else begin
          act = 0; p1v = 0;
        end
      end else if (act) begin
        cnt[1:0] = cnt[1:0] + 2'd1;
        p1v = 1; p1w = dirw; p1a = cnt;
      end else begin
        p1v = 0;
      end
      p1be = pbe; p1d = pd;
    end
    @(negedge clk);
    compare();
  endtask

  function automatic logic [AW-1:0] ra(); return AW'($urandom); endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
    cyc(0, 0, 0, 0, 0, a, be, d);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    cyc(0, 0, 0, 0, 1, a, 4'($urandom), $urandom);
  endtask
  task automatic adv(input logic [3:0] be, input logic [31:0] d);
    cyc(0, 0, $urandom, 1, $urandom, ra(), be, d);
  endtask
  task automatic desel();
    cyc(0, 0, 1, 0, $urandom, ra(), 4'($urandom), $urandom);
  endtask
  task automatic stall();
    cyc(0, 1, $urandom, $urandom, $urandom, ra(), 4'($urandom), $urandom);
  endtask
  task automatic flush();
    desel(); desel();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    @(negedge clk);
    // R11: reset clears outputs and pipeline; step after reset is idle
    tag = "R11";
    repeat (3) cyc(1, 0, 0, 0, 1, ra(), 4'hF, 0);
    tag = "R7";
    repeat (3) adv(4'h0, $urandom);
    // R1: full-word writes with loads
    tag = "R1";
    for (int i = 0; i < 64; i++) wr(AW'(i), 4'b0000, 32'hA5000000 ^ (i * 32'h01030507));
    flush();
    // R2: back-to-back reads
    tag = "R2";
    rd(5); rd(9); rd(63); rd(0); flush();
    // R9: single lanes and a subset
    tag = "R9";
    for (int l = 0; l < 4; l++) wr(AW'(10 + l), ~(4'b1 << l), 32'hC3C3C3C3);
    wr(14, 4'b0101, 32'h11223344);
    for (int l = 0; l < 5; l++) rd(AW'(10 + l));
    flush();
    // R5: write burst from bit pattern 2 wraps to 0 and 1
    tag = "R5";
    wr(18, 4'b0000, 32'hB0000001);
    adv(4'b0000, 32'hB0000002); adv(4'b0000, 32'hB0000003); adv(4'b0110, 32'hB0000004);
    flush();
    // R4: read burst with direction pin toggling and random addresses
    tag = "R4";
    rd(16); adv(4'hF, 0); adv(4'hF, 0); adv(4'hF, 0); adv(4'hF, 0);
    flush();
    // R10: alternating write/read on the same word, no gaps
    tag = "R10";
    wr(30, 4'b0000, 32'hDEADBEEF); rd(30); wr(31, 4'b1100, 32'h0000CAFE); rd(31);
    wr(30, 4'b1011, 32'h00770000); rd(30); rd(31);
    flush();
    // R6: deselect drops the output enable two edges later
    tag = "R6";
    rd(5); desel(); desel(); desel();
    tag = "R7";
    adv(4'b0000, 32'hFFFFFFFF); adv(4'b0000, 32'hFFFFFFFF); rd(5); flush();
    // R8: stalls inside a read burst and between a write and its data slot
    tag = "R8";
    rd(40); adv(4'hF, 0); stall(); stall(); stall(); adv(4'hF, 0); adv(4'hF, 0);
    wr(41, 4'b0000, 32'h5A5A0F0F); stall(); stall(); rd(41); stall(); rd(40);
    flush();
    // R3: random mix; payload pins random outside the write slot
    tag = "R3";
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      if (k < 2) stall();
      else if (k < 4) wr(AW'($urandom_range(0, 63)), 4'($urandom), $urandom);
      else if (k < 7) rd(AW'($urandom_range(0, 63)));
      else if (k < 9) adv(4'($urandom), $urandom);
      else desel();
    end
    flush();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

endmodule